// File: doc/BRIEF.md
# POST-Code Capture FIFO

This block records the progress bytes that platform firmware writes to the host I/O port at address 0x0080 during boot. Each qualifying host write puts its data byte into a small first-in first-out store. The local processor drains that store through a four-register interface and sees a level interrupt whenever the host has written. The processor can enable or disable capture, and it chooses how the strobe is qualified.

Status flags report whether bytes are waiting, whether a byte was lost to a full store, and whether any host write has happened since the last acknowledge. The processor reads the buffer register in one of two ways. It can consume one byte per read, or it can look at the oldest byte without removing it. When the store is empty, a buffer read repeats the byte it last delivered.

Top module: `postcode_capture`

## Requirements
- R1: After reset, the control register, the status register and the buffer read all return 0x00, and `irq` is low.
- R2: A host write is captured only when control bit 0 (enable) is 1 and `host_addr` equals 0x0080. A write to any other address, or any write while enable is 0, leaves the store and the flags unchanged.
- R3: Control bit 3 (sync mode) selects how the strobe is qualified. When it is 1, every clock cycle with a qualifying strobe high is one write. When it is 0, a strobe held high counts as only one write, taken on its rising edge.
- R4: Status bit 0 (not-empty) is 1 exactly while the store holds at least one byte.
- R5: Reading register 2 returns the oldest stored byte. When control bit 2 (auto-advance) is 1, that read also removes the byte. When it is 0, the read leaves the store unchanged.
- R6: The store holds 16 bytes. A captured write that arrives while the store is full drops its byte, keeps the existing bytes, and sets status bit 1 (overflow). Overflow stays set until the processor writes 1 to status bit 1.
- R7: Status bit 2 (write-pending) is set by every captured write, whether stored or dropped, while control bit 1 (interrupt enable) is 1. Writing 1 to status bit 2 clears it, but a capture in the same cycle keeps it set.
- R8: `irq` is high exactly while write-pending is 1 and interrupt enable is 1.
- R9: Reading register 2 while the store is empty returns the byte most recently delivered by a register 2 read and does not change the store.
- R10: A register read returns its data on `reg_rdata` in the cycle after `reg_rd` is sampled. Register 0 returns the four control bits, and register 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host I/O write strobe |
| host_addr | input | 16 | Host I/O address |
| host_data | input | 8 | Host write data |
| reg_wr | input | 1 | Processor register write strobe |
| reg_rd | input | 1 | Processor register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 buffer, 3 reserved |
| reg_wdata | input | 8 | Processor write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt to the processor |

## Verification
A host write is sampled on one clock edge, and the store, the flags and `irq` all change on that same edge. The bench therefore checks `irq` and status on the falling edge that follows the write. A register read also takes effect on the edge where it is sampled, so its value is due on the next falling edge. The driver queues the expected value when it issues the read, and a monitor compares exactly one cycle later. Scenarios that depend on strobe width add an idle low cycle after each write, so that the edge-qualified mode sees distinct rising edges.

// File: rtl/pcc_pkg.sv
// Shared register addresses, bit positions and the control register type.
package pcc_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_BUF  = 2'd2;

    localparam int S_NE   = 0;
    localparam int S_OVF  = 1;
    localparam int S_PEND = 2;

    typedef struct packed {
        logic sync;   // bit 3
        logic aa;     // bit 2
        logic ie;     // bit 1
        logic en;     // bit 0
    } ctrl_t;
endpackage

// File: rtl/pcc_host_port.sv
// Qualifies host writes to the debug port address.
// Sync mode: each high strobe cycle is a write. Otherwise: rising edge only.
// Assumes host signals are already synchronous to clk.
module pcc_host_port #(
    parameter int              AW   = 16,
    parameter int              DW   = 8,
    parameter logic [AW-1:0]   PORT = 16'h0080
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_mode,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_data,
    output logic          wr_evt,
    output logic [DW-1:0] wr_byte
);
    logic hit;
    logic hit_q;

    assign hit     = host_wr && (host_addr == PORT);
    assign wr_evt  = hit && (sync_mode || !hit_q);
    assign wr_byte = host_data;

    // Remember last cycle's qualified strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && wr_evt) |=> (sync_mode || !wr_evt)); // R3
endmodule

// File: rtl/pcc_fifo.sv
// Circular byte store with occupancy count.
// Pushes into a full store and pops from an empty store are ignored.
module pcc_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Store the incoming byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R6
    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(rptr))); // R6
endmodule

// File: rtl/pcc_csr.sv
// Processor-side registers: control, sticky status flags, buffer read port.
// Drives the store's push and pop and the level interrupt.
// Assumes at most one of reg_wr and reg_rd per cycle.
module pcc_csr #(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [1:0]     reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           wr_evt,
    input  logic           fifo_empty,
    input  logic           fifo_full,
    input  logic [DW-1:0]  fifo_head,
    output logic           fifo_push,
    output logic           fifo_pop,
    output pcc_pkg::ctrl_t ctrl,
    output logic           irq
);
    import pcc_pkg::*;

    logic          ovf, pend;
    logic          capture, buf_rd, stat_wr, ovf_set, pend_set;
    logic [DW-1:0] last_q;
    logic [3:0]    ctrl_bits;
    logic [2:0]    stat_bits;
    logic          unused_wdata;

    assign capture   = wr_evt && ctrl.en;
    assign fifo_push = capture;
    assign ovf_set   = capture && fifo_full;
    assign pend_set  = capture && ctrl.ie;
    assign buf_rd    = reg_rd && (reg_addr == A_BUF);
    assign stat_wr   = reg_wr && (reg_addr == A_STAT);
    assign fifo_pop  = buf_rd && ctrl.aa && !fifo_empty;
    assign irq       = pend && ctrl.ie;
    assign ctrl_bits = ctrl;
    assign stat_bits = {pend, ovf, !fifo_empty};
    assign unused_wdata = ^reg_wdata;

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl <= '0;
        else if (reg_wr && reg_addr == A_CTRL) ctrl <= ctrl_t'(reg_wdata[3:0]);
    end

    // Sticky overflow flag, write-1-to-clear; a new overflow wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf <= 1'b0;
        else if (ovf_set)                    ovf <= 1'b1;
        else if (stat_wr && reg_wdata[S_OVF]) ovf <= 1'b0;
    end

    // Write-pending flag, write-1-to-clear; a new capture wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                           pend <= 1'b0;
        else if (pend_set)                    pend <= 1'b1;
        else if (stat_wr && reg_wdata[S_PEND]) pend <= 1'b0;
    end

    // Keep the byte last delivered by a non-empty buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n)                     last_q <= '0;
        else if (buf_rd && !fifo_empty) last_q <= fifo_head;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (reg_rd) begin
            case (reg_addr)
                A_CTRL:  reg_rdata <= DW'(ctrl_bits);
                A_STAT:  reg_rdata <= DW'(stat_bits);
                A_BUF:   reg_rdata <= fifo_empty ? last_q : fifo_head;
                default: reg_rdata <= '0;
            endcase
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(stat_wr && reg_wdata[S_OVF])) |=> ovf); // R6
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[S_PEND] && !wr_evt) |=> !pend); // R7
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set) |=> irq || !ctrl.ie); // R8
endmodule

// File: rtl/postcode_capture.sv
// Top: host debug-port capture into a byte store drained by the processor.
// Assumes all inputs are synchronous to clk.
module postcode_capture #(
    parameter int            DW        = 8,
    parameter int            DEPTH     = 16,
    parameter int            HAW       = 16,
    parameter logic [HAW-1:0] PORT_ADDR = 16'h0080
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_wr,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_data,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [1:0]     reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           irq
);
    localparam int CW = $clog2(DEPTH+1);

    pcc_pkg::ctrl_t ctrl;
    logic           wr_evt, push, pop, empty, full;
    logic [DW-1:0]  wr_byte, head;
    logic [CW-1:0]  count;

    pcc_host_port #(.AW(HAW), .DW(DW), .PORT(PORT_ADDR)) u_port (
        .clk(clk), .rst_n(rst_n), .sync_mode(ctrl.sync),
        .host_wr(host_wr), .host_addr(host_addr), .host_data(host_data),
        .wr_evt(wr_evt), .wr_byte(wr_byte)
    );

    pcc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(wr_byte), .pop(pop),
        .head(head), .empty(empty), .full(full), .count(count)
    );

    pcc_csr #(.DW(DW)) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wr_evt(wr_evt), .fifo_empty(empty), .fifo_full(full),
        .fifo_head(head), .fifo_push(push), .fifo_pop(pop),
        .ctrl(ctrl), .irq(irq)
    );

    AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !pop) |=> $stable(count)); // R2
    AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == pcc_pkg::A_BUF && empty && !push) |=> (count == '0)); // R9
endmodule

// File: tb/test_postcode_capture.sv
// Scoreboard bench: read tasks queue expectations, a monitor compares one cycle later.
module test_postcode_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0] host_data = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int compared = 0, mismatched = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    postcode_capture i_postcode_capture (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // Note which cycles carried a read strobe.
    always @(posedge clk) rd_seen <= reg_rd;

    // Monitor: compare registered read data against the queued expectation.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (reg_rdata !== e) begin
                mismatched++;
                $display("FAIL %s: rdata=%02h expected=%02h", t, reg_rdata, e);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%02h expected=%02h", t, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Strobe high for n cycles, then one idle cycle.
    task automatic hw(input logic [15:0] a, input logic [7:0] d, input int n);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_data = d;
        for (int i = 0; i < n; i++) @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        mismatched++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({7'b0, irq}, 8'h00, "R1 irq");
        rd(2'd0, 8'h00, "R1 ctrl");
        rd(2'd1, 8'h00, "R1 status");
        rd(2'd2, 8'h00, "R1 buffer");
        // R2 disabled capture ignored
        hw(16'h0080, 8'h11, 1);
        rd(2'd1, 8'h00, "R2 disabled");
        wr(2'd0, 8'h0F);
        rd(2'd0, 8'h0F, "R10 ctrl readback");
        rd(2'd3, 8'h00, "R10 reserved");
        // R2 wrong address ignored
        hw(16'h0081, 8'h22, 1);
        rd(2'd1, 8'h00, "R2 other address");
        // R4 R7 R8 capture raises pending and irq
        hw(16'h0080, 8'hA5, 1);
        chk({7'b0, irq}, 8'h01, "R8 irq high");
        rd(2'd1, 8'h05, "R4 R7 status");
        wr(2'd1, 8'h04);
        chk({7'b0, irq}, 8'h00, "R8 irq cleared");
        rd(2'd1, 8'h01, "R7 pending cleared");
        // R5 auto-advance drain
        hw(16'h0080, 8'h3C, 1);
        wr(2'd1, 8'h04);
        rd(2'd2, 8'hA5, "R5 pop first");
        rd(2'd2, 8'h3C, "R5 pop second");
        rd(2'd1, 8'h00, "R4 empty");
        // R9 empty read repeats last
        rd(2'd2, 8'h3C, "R9 empty read");
        rd(2'd1, 8'h00, "R9 still empty");
        // R5 peek without auto-advance
        wr(2'd0, 8'h0B);
        hw(16'h0080, 8'h77, 1);
        rd(2'd2, 8'h77, "R5 peek 1");
        rd(2'd2, 8'h77, "R5 peek 2");
        rd(2'd1, 8'h05, "R5 peek keeps");
        wr(2'd0, 8'h0F);
        rd(2'd2, 8'h77, "R5 pop after peek");
        wr(2'd1, 8'h04);
        rd(2'd1, 8'h00, "R4 empty again");
        // R3 sync mode: strobe held two cycles gives two entries
        hw(16'h0080, 8'h61, 2);
        rd(2'd2, 8'h61, "R3 sync first");
        rd(2'd1, 8'h05, "R3 sync second remains");
        rd(2'd2, 8'h61, "R3 sync second");
        wr(2'd1, 8'h04);
        rd(2'd1, 8'h00, "R3 sync drained");
        // R6 fill, overflow, drain
        for (int i = 0; i < 16; i++) hw(16'h0080, 8'(i * 3 + 1), 1);
        hw(16'h0080, 8'hEE, 1);
        rd(2'd1, 8'h07, "R6 overflow set");
        for (int i = 0; i < 16; i++) rd(2'd2, 8'(i * 3 + 1), "R6 drain order");
        rd(2'd2, 8'(15 * 3 + 1), "R9 after drain");
        rd(2'd1, 8'h06, "R6 sticky");
        wr(2'd1, 8'h02);
        rd(2'd1, 8'h04, "R6 overflow cleared");
        wr(2'd1, 8'h04);
        rd(2'd1, 8'h00, "R7 cleared");
        // R3 edge mode: held strobe counts once
        wr(2'd0, 8'h07);
        hw(16'h0080, 8'h42, 3);
        rd(2'd2, 8'h42, "R3 edge byte");
        rd(2'd1, 8'h04, "R3 edge single entry");
        hw(16'h0080, 8'h50, 1);
        hw(16'h0080, 8'h51, 1);
        rd(2'd2, 8'h50, "R3 edge two writes a");
        rd(2'd2, 8'h51, "R3 edge two writes b");
        wr(2'd1, 8'h04);
        // R7 R8 no pending without interrupt enable
        wr(2'd0, 8'h05);
        hw(16'h0080, 8'h99, 1);
        chk({7'b0, irq}, 8'h00, "R8 irq stays low");
        rd(2'd1, 8'h01, "R7 no pending");
        rd(2'd2, 8'h99, "R2 captured enabled");
        repeat (3) @(negedge clk);
        chk(8'(exp_q.size()), 8'h00, "scoreboard drained");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule